// File: doc/BRIEF.md
# Four-Line Swap Victim Cache

This block sits between a first-level data cache and main memory and holds up to four lines that the first-level cache has recently thrown out. Each line carries a valid bit, a dirty bit, a 10-bit tag and two 32-bit words. When the first-level cache misses, it raises a request. The request carries the tag it wants and the line it is evicting. All four stored tags are compared in parallel. On a hit, the stored line and its dirty bit go straight back to the first-level cache, and the evicted line takes over the freed slot.

On a miss, the block deals with the oldest slot. If that slot holds a dirty line, the line is first written back to memory. The requested line is then read from memory and passed up. The evicted line is placed in the oldest slot, which advances a first-in first-out pointer. Memory sees only this block as a requester, one single access at a time. The first-level cache sees a wait signal that rises for as long as memory work is in progress.

Top module: `victim_cache`

## Requirements
- R1: After reset, all lines are invalid, the FIFO pointer is at slot 0, and `l1_wait`, `l1_valid` and `mem_req` are low.
- R2: A request accepted in the idle state whose tag matches a valid line is a hit. One cycle after acceptance, `l1_valid` is high and `l1_rdata` holds that line's data (word 0 in bits 31:0, word 1 in bits 63:32). `l1_rdirty` holds its dirty bit. No memory access is made and `l1_wait` stays low.
- R3: On a hit, the evicted line takes the hitting line's slot. If the evicted line is invalid, that slot becomes invalid. A later request for the returned tag misses, and a request for the evicted tag hits.
- R4: On a miss, exactly one memory read is made at the requested tag. One cycle after the read is acknowledged, `l1_valid` is high, `l1_rdata` holds the memory data and `l1_rdirty` is 0.
- R5: On a miss, if the slot under the FIFO pointer holds a valid dirty line, that line's tag and data are written to memory before the read. Otherwise, no write is made.
- R6: On a miss with a valid evicted line, that line is stored in the slot under the pointer, and the pointer then advances by one, wrapping from 3 to 0. A hit never moves the pointer.
- R7: On a miss with an invalid evicted line, nothing is stored and the pointer does not move.
- R8: `l1_wait` is high exactly while a memory write-back or read is outstanding.
- R9: `mem_burst` is always low. `mem_req` is high only during a write-back or read, and `mem_we` is high only during a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l1_req | input | 1 | Miss request from the first-level cache, sampled when idle |
| l1_req_tag | input | 10 | Tag of the wanted line |
| l1_ev_valid | input | 1 | Evicted line valid |
| l1_ev_dirty | input | 1 | Evicted line dirty |
| l1_ev_tag | input | 10 | Evicted line tag |
| l1_ev_data | input | 64 | Evicted line data |
| l1_wait | output | 1 | Memory activity in progress |
| l1_valid | output | 1 | Returned line present this cycle |
| l1_rdata | output | 64 | Returned line data |
| l1_rdirty | output | 1 | Returned line dirty bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_burst | output | 1 | Burst select, held low |
| mem_addr | output | 10 | Memory line tag |
| mem_wdata | output | 64 | Write-back data |
| mem_ack | input | 1 | One-cycle completion pulse from memory |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |

## Verification
On every cycle, the assertions check the following:
- a hit returns a line on the next cycle without touching memory;
- a write-back is always followed by a read;
- an acknowledged read returns a clean line on the next cycle;
- a miss raises the wait signal;
- the FIFO pointer only moves on an insertion of a valid line.

Some behaviours need the bench's reference model of slot contents across many requests:
- which slot a line lands in;
- the swap contents;
- the exact tag and data written back;
- the frozen pointer after an invalid eviction.

// File: rtl/vc_pkg.sv
package vc_pkg;
  parameter int VC_TAG_W  = 10;
  parameter int VC_WORD_W = 32;
  parameter int VC_WORDS  = 2;
  parameter int VC_LINES  = 4;
  localparam int VC_LINE_W = VC_WORD_W * VC_WORDS;
  localparam int VC_IDX_W  = (VC_LINES > 1) ? $clog2(VC_LINES) : 1;

  typedef struct packed {
    logic                 valid;
    logic                 dirty;
    logic [VC_TAG_W-1:0]  tag;
    logic [VC_LINE_W-1:0] data;
  } vc_line_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_RD   = 2'd2,
    ST_RET  = 2'd3
  } vc_state_e;
endpackage

// File: rtl/vc_store.sv
module vc_store
  import vc_pkg::*;
#(
  parameter int LINES = VC_LINES,
  localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VC_TAG_W-1:0] look_tag,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  vc_line_t            wr_line,
  input  logic                adv,
  output logic                hit,
  output logic [IW-1:0]       hit_idx,
  output vc_line_t            pick_line,
  output logic [IW-1:0]       ptr
);
  logic [LINES-1:0]     vld_q;
  logic [LINES-1:0]     dty_q;
  logic [VC_TAG_W-1:0]  tag_q [LINES];
  logic [VC_LINE_W-1:0] dat_q [LINES];
  logic [LINES-1:0]     match;
  logic [IW-1:0]        ptr_q, ptr_d, sel;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == look_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end

  assign hit = |match;
  assign sel = hit ? hit_idx : ptr_q;
  assign pick_line = '{valid: vld_q[sel], dirty: dty_q[sel],
                       tag: tag_q[sel], data: dat_q[sel]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_line.valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      dty_q[wr_idx] <= wr_line.dirty;
      tag_q[wr_idx] <= wr_line.tag;
      dat_q[wr_idx] <= wr_line.data;
    end
  end

  always_comb ptr_d = adv ? ptr_q + 1'b1 : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R7
  adv_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (wr_en && wr_line.valid));
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
#(
  parameter int LINES = VC_LINES,
  localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 l1_req,
  input  logic [VC_TAG_W-1:0]  l1_req_tag,
  input  vc_line_t             ev_line,
  input  logic                 hit,
  input  logic [IW-1:0]        hit_idx,
  input  vc_line_t             pick_line,
  input  logic [IW-1:0]        ptr,
  input  logic                 mem_ack,
  input  logic [VC_LINE_W-1:0] mem_rdata,
  output logic                 wr_en,
  output logic [IW-1:0]        wr_idx,
  output vc_line_t             wr_line,
  output logic                 adv,
  output logic                 l1_wait,
  output logic                 l1_valid,
  output logic [VC_LINE_W-1:0] l1_rdata,
  output logic                 l1_rdirty,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [VC_TAG_W-1:0]  mem_addr,
  output logic [VC_LINE_W-1:0] mem_wdata
);
  vc_state_e           state_q, state_d;
  vc_line_t            hold1_q, hold1_d, hold2_q, hold2_d;
  logic                hit_q, hit_d;
  logic [IW-1:0]       slot_q, slot_d;
  logic [VC_TAG_W-1:0] rtag_q, rtag_d;
  logic                accept;

  assign accept = (state_q == ST_IDLE) && l1_req;

  always_comb begin
    state_d = state_q;
    hold1_d = hold1_q;
    hold2_d = hold2_q;
    hit_d   = hit_q;
    slot_d  = slot_q;
    rtag_d  = rtag_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        hold1_d = ev_line;
        hold2_d = pick_line;
        hit_d   = hit;
        slot_d  = hit ? hit_idx : ptr;
        rtag_d  = l1_req_tag;
        if (hit)                                   state_d = ST_RET;
        else if (pick_line.valid && pick_line.dirty) state_d = ST_WB;
        else                                       state_d = ST_RD;
      end
      ST_WB: if (mem_ack) state_d = ST_RD;
      ST_RD: if (mem_ack) begin
        hold2_d = '{valid: 1'b1, dirty: 1'b0, tag: rtag_q, data: mem_rdata};
        state_d = ST_RET;
      end
      ST_RET: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    hold1_q <= hold1_d;
    hold2_q <= hold2_d;
    hit_q   <= hit_d;
    slot_q  <= slot_d;
    rtag_q  <= rtag_d;
  end

  assign mem_req   = (state_q == ST_WB) || (state_q == ST_RD);
  assign mem_we    = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_WB) ? hold2_q.tag : rtag_q;
  assign mem_wdata = hold2_q.data;
  assign l1_wait   = mem_req;
  assign l1_valid  = (state_q == ST_RET);
  assign l1_rdata  = hold2_q.data;
  assign l1_rdirty = hold2_q.dirty;

  assign wr_en   = (state_q == ST_RET) && (hit_q || hold1_q.valid);
  assign wr_idx  = slot_q;
  assign wr_line = hold1_q;
  assign adv     = (state_q == ST_RET) && !hit_q && hold1_q.valid;

  // R2
  hit_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (l1_valid && !mem_req));
  // R4
  rd_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (l1_valid && !l1_rdirty));
  // R5
  wb_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
  // R8
  miss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> l1_wait);
  // R9
  ret_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_valid |=> !mem_req);
endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int LINES = VC_LINES,
  localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 l1_req,
  input  logic [VC_TAG_W-1:0]  l1_req_tag,
  input  logic                 l1_ev_valid,
  input  logic                 l1_ev_dirty,
  input  logic [VC_TAG_W-1:0]  l1_ev_tag,
  input  logic [VC_LINE_W-1:0] l1_ev_data,
  output logic                 l1_wait,
  output logic                 l1_valid,
  output logic [VC_LINE_W-1:0] l1_rdata,
  output logic                 l1_rdirty,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 mem_burst,
  output logic [VC_TAG_W-1:0]  mem_addr,
  output logic [VC_LINE_W-1:0] mem_wdata,
  input  logic                 mem_ack,
  input  logic [VC_LINE_W-1:0] mem_rdata
);
  vc_line_t      ev_line, wr_line, pick_line;
  logic          hit, wr_en, adv;
  logic [IW-1:0] hit_idx, wr_idx, ptr;

  assign ev_line = '{valid: l1_ev_valid, dirty: l1_ev_dirty,
                     tag: l1_ev_tag, data: l1_ev_data};
  assign mem_burst = 1'b0;

  vc_store #(.LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_n), .look_tag(l1_req_tag),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_line(wr_line), .adv(adv),
    .hit(hit), .hit_idx(hit_idx), .pick_line(pick_line), .ptr(ptr)
  );

  vc_ctrl #(.LINES(LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .l1_req(l1_req), .l1_req_tag(l1_req_tag),
    .ev_line(ev_line), .hit(hit), .hit_idx(hit_idx), .pick_line(pick_line),
    .ptr(ptr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_line(wr_line), .adv(adv),
    .l1_wait(l1_wait), .l1_valid(l1_valid), .l1_rdata(l1_rdata),
    .l1_rdirty(l1_rdirty), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/victim_cache_tb.sv
`timescale 1ns/1ps
module victim_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l1_req = 1'b0;
  logic [9:0]  l1_req_tag = '0;
  logic        l1_ev_valid = 1'b0, l1_ev_dirty = 1'b0;
  logic [9:0]  l1_ev_tag = '0;
  logic [63:0] l1_ev_data = '0;
  logic        l1_wait, l1_valid, l1_rdirty;
  logic [63:0] l1_rdata;
  logic        mem_req, mem_we, mem_burst;
  logic [9:0]  mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int mcnt = 0, rd_cnt = 0;
  logic [9:0]  wb_addr_q [$];
  logic [63:0] wb_data_q [$];

  // reference model state
  bit          m_v [4];
  bit          m_d [4];
  logic [9:0]  m_t [4];
  logic [63:0] m_dat [4];
  int          m_ptr = 0;

  always #2.5 clk = ~clk;

  victim_cache u_dut (.*);

  function automatic logic [63:0] mpat(input logic [9:0] t);
    return {16'hC0DE, 6'd0, t, 16'h5EED, 6'd0, t};
  endfunction

  function automatic logic [63:0] epat(input logic [9:0] t);
    return {16'hD1A7, 6'd0, t, 16'h0B0E, 6'd0, t};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: acknowledges each access after three cycles
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mcnt = mcnt + 1;
      if (mcnt == 3) begin
        mcnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          wb_addr_q.push_back(mem_addr);
          wb_data_q.push_back(mem_wdata);
        end else begin
          rd_cnt++;
          mem_rdata <= mpat(mem_addr);
        end
      end
    end else begin
      mcnt = 0;
    end
  end

  task automatic do_req(input bit ev_v, input bit ev_d, input logic [9:0] ev_t,
                        input logic [9:0] rq);
    bit          hit = 0, exp_wb = 0;
    int          idx = 0, cyc, wb0, rd0;
    logic [63:0] exp_data;
    bit          exp_dirty;
    logic [9:0]  wb_t = '0;
    logic [63:0] wb_d = '0;
    for (int i = 0; i < 4; i++)
      if (!hit && m_v[i] && m_t[i] == rq) begin hit = 1; idx = i; end
    if (hit) begin
      exp_data = m_dat[idx]; exp_dirty = m_d[idx];
      m_v[idx] = ev_v; m_d[idx] = ev_d; m_t[idx] = ev_t; m_dat[idx] = epat(ev_t);
    end else begin
      exp_data = mpat(rq); exp_dirty = 0;
      exp_wb = m_v[m_ptr] && m_d[m_ptr];
      wb_t = m_t[m_ptr]; wb_d = m_dat[m_ptr];
      if (ev_v) begin
        m_v[m_ptr] = 1; m_d[m_ptr] = ev_d; m_t[m_ptr] = ev_t; m_dat[m_ptr] = epat(ev_t);
        m_ptr = (m_ptr + 1) % 4;
      end
    end
    @(negedge clk);
    l1_req = 1; l1_req_tag = rq;
    l1_ev_valid = ev_v; l1_ev_dirty = ev_d; l1_ev_tag = ev_t; l1_ev_data = epat(ev_t);
    wb0 = wb_addr_q.size(); rd0 = rd_cnt;
    @(negedge clk);
    l1_req = 0; l1_ev_valid = 0;
    cyc = 1;
    while (!l1_valid && cyc < 60) begin
      chk(l1_wait == mem_req, "R8", "wait vs memory activity", 64'(l1_wait), 64'(mem_req));
      chk(!mem_burst && (!mem_we || mem_req), "R9", "burst/we", {mem_burst, mem_we}, 64'(0));
      @(negedge clk);
      cyc++;
    end
    chk(l1_valid, hit ? "R2" : "R4", "return seen", 64'(l1_valid), 64'(1));
    if (hit) begin
      chk(cyc == 1, "R2", "hit latency", 64'(cyc), 64'(1));
      chk(l1_rdata == exp_data, "R2", "hit data", l1_rdata, exp_data);
      chk(l1_rdirty == exp_dirty, "R2", "hit dirty", 64'(l1_rdirty), 64'(exp_dirty));
    end else begin
      chk(l1_rdata == exp_data, "R4", "miss data", l1_rdata, exp_data);
      chk(l1_rdirty == 0, "R4", "miss dirty", 64'(l1_rdirty), 64'(0));
    end
    chk(rd_cnt - rd0 == (hit ? 0 : 1), "R4", "read count", 64'(rd_cnt - rd0), 64'(hit ? 0 : 1));
    chk(wb_addr_q.size() - wb0 == int'(exp_wb), "R5", "write-back count",
        64'(wb_addr_q.size() - wb0), 64'(exp_wb));
    if (exp_wb && wb_addr_q.size() > wb0) begin
      chk(wb_addr_q[wb0] == wb_t, "R5", "write-back tag", 64'(wb_addr_q[wb0]), 64'(wb_t));
      chk(wb_data_q[wb0] == wb_d, "R5", "write-back data", wb_data_q[wb0], wb_d);
    end
    @(negedge clk);
    chk(!l1_valid && !l1_wait && !mem_req, "R8", "idle after return",
        {l1_valid, l1_wait, mem_req}, 64'(0));
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_d[i] = 0; m_t[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!l1_wait && !l1_valid && !mem_req, "R1", "reset outputs",
        {l1_wait, l1_valid, mem_req}, 64'(0));
    rst_n = 1;
    @(negedge clk);
    do_req(0, 0, 10'h000, 10'h001);   // R7: invalid eviction, nothing stored
    do_req(1, 1, 10'h010, 10'h002);   // R6: slot 0
    do_req(1, 0, 10'h011, 10'h003);   // R6: slot 1
    do_req(1, 1, 10'h012, 10'h004);   // R6: slot 2
    do_req(1, 1, 10'h013, 10'h005);   // R6: slot 3, pointer wraps
    do_req(1, 0, 10'h020, 10'h012);   // R2 R3: dirty hit, swap in 0x020
    do_req(0, 0, 10'h000, 10'h020);   // R3: hit on swapped line, slot emptied
    do_req(1, 0, 10'h040, 10'h012);   // R3: returned tag now misses; R5 dirty victim 0x010
    do_req(1, 1, 10'h021, 10'h030);   // R5: clean victim 0x011, no write
    do_req(0, 0, 10'h000, 10'h032);   // R7: pointer stays on emptied slot
    do_req(1, 1, 10'h023, 10'h033);   // R6: fills emptied slot
    do_req(1, 0, 10'h024, 10'h034);   // R5: dirty victim 0x013
    do_req(1, 1, 10'h025, 10'h021);   // R2: hit on dirty line
    do_req(1, 0, 10'h026, 10'h040);   // R2: hit on clean line
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule